// File: doc/BRIEF.md
# Power-Good and Power-Down Sequencer

This block sequences the clock subsystem from a single board-level pin that changes meaning once. At start-up the pin is read as a power-good indication. The first sustained high level does three things: it fires a one-cycle strobe that captures the strap inputs, it turns on the oscillator and PLL enables, and it starts a lock window. When the window has elapsed, a global run signal releases the output gating. From then on the same pin is an active-low power-down request. Driving it low first parks the outputs, and the oscillator and PLL enables drop only after that. Driving it high again restarts the lock window without a second strap capture.

The pin is asynchronous. It passes through a flop synchronizer and then a level filter, so a pulse shorter than the filter length never reaches the state machine. The sequencer runs on an always-on reference clock, so the wake-up path keeps working while the oscillator enable is low. The lock window and the park window are parameters counted in reference cycles. The default lock window is 1.8 ms at 100 MHz, and a testbench shortens it.

Top module: `pwr_seq_top`

## Requirements
- R1: While reset is asserted and after its release, with the pin low, strap_latch_o, osc_en_o, pll_en_o and out_run_o are all 0.
- R2: strap_latch_o is high for exactly one cycle in the whole run after reset, on the first sustained high level of the pin, and never again on later wake-ups.
- R3: The pin passes SYNC_STAGES synchronizer flops and then a filter that needs FILT_LEN equal consecutive samples. A level held for fewer than FILT_LEN cycles changes no output. A held change moves the state SYNC_STAGES+FILT_LEN+1 cycles after it is first sampled.
- R4: After the first power-good, pll_en_o and osc_en_o are high with out_run_o low for LOCK_CYC+1 cycles: one strobe cycle followed by LOCK_CYC lock cycles. After that, out_run_o rises.
- R5: A filtered low level while running drops out_run_o in the next cycle. osc_en_o and pll_en_o then stay high for exactly STOP_CYC further cycles before both fall.
- R6: out_run_o is never high unless both pll_en_o and osc_en_o are high.
- R7: From the off state, a sustained high level raises the enables and holds out_run_o low for exactly LOCK_CYC cycles, with no strap strobe.
- R8: A filtered low level during the lock window goes straight to the off state (all outputs 0), and out_run_o is never asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pg_pd_n_i | input | 1 | Dual-function pin: power-good first, then active-low power-down (asynchronous) |
| strap_latch_o | output | 1 | One-cycle strobe that captures the strap inputs |
| osc_en_o | output | 1 | Crystal oscillator enable |
| pll_en_o | output | 1 | PLL and VCO enable |
| out_run_o | output | 1 | Global release of the clock output gating |

## Verification
The assertions check on every cycle that the run signal is only high while both enables are high. They also check that an enable only falls after the outputs have already been parked, that the strap strobe lasts one cycle and is followed by live enables, that the run signal only rises when the lock timer expires, and that the filter only changes its level when its whole history agrees. Some behaviours can only be shown by the bench's scenarios, which compare against a cycle-accurate reference model: the exact lengths of the lock and park windows, the rejection of short glitches in the waiting, running and off states, the single strap capture across several wake-ups, and the abort of a lock window.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [2:0] {
    ST_WAIT_PG = 3'd0,
    ST_LATCH   = 3'd1,
    ST_LOCK    = 3'd2,
    ST_RUN     = 3'd3,
    ST_STOP    = 3'd4,
    ST_OFF     = 3'd5
  } seq_state_e;

  // Counter width able to hold the larger of two window lengths.
  function automatic int unsigned tmr_width(int unsigned a, int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction

  // States in which the oscillator and PLL must be powered.
  function automatic logic clocks_live(seq_state_e s);
    return (s == ST_LATCH) || (s == ST_LOCK) || (s == ST_RUN) || (s == ST_STOP);
  endfunction

endpackage

// File: rtl/pwr_pin_filter.sv
module pwr_pin_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;
  logic                   level_q;
  logic                   all_hi, all_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= '0;
    end else begin
      sync_q[0] <= pin_i;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      hist_q[0] <= sync_q[SYNC_STAGES-1];
      for (int i = 1; i < FILT_LEN; i++) hist_q[i] <= hist_q[i-1];
    end
  end

  assign all_hi = &hist_q;
  assign all_lo = ~|hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      level_q <= 1'b0;
    else if (all_hi) level_q <= 1'b1;
    else if (all_lo) level_q <= 1'b0;
  end

  assign level_o = level_q;

  // R3: the filtered level only rises after the whole history was high
  p_filter_agree_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(level_q) |-> ($past(hist_q[0]) && $past(hist_q[FILT_LEN-1])));

  // R3: the filtered level only falls after the whole history was low
  p_filter_agree_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(level_q) |-> (!$past(hist_q[0]) && !$past(hist_q[FILT_LEN-1])));

endmodule

// File: rtl/pwr_win_timer.sv
module pwr_win_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic         done_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load_i)         cnt_q <= len_i - W'(1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - W'(1);
  end

  assign done_o = (cnt_q == '0);

  // R4: a load with a window longer than one cycle is not done next cycle
  p_load_not_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && (len_i > W'(1))) |=> !done_o);

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3,
  parameter int unsigned LOCK_CYC    = 180000,
  parameter int unsigned STOP_CYC    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pg_pd_n_i,
  output logic strap_latch_o,
  output logic osc_en_o,
  output logic pll_en_o,
  output logic out_run_o
);
  import pwr_seq_pkg::*;

  localparam int unsigned TW = tmr_width(LOCK_CYC, STOP_CYC);
  localparam logic [TW-1:0] LOCK_LEN = TW'(LOCK_CYC);
  localparam logic [TW-1:0] STOP_LEN = TW'(STOP_CYC);

  seq_state_e state_q, state_d;
  logic       pin_lvl;
  logic       tmr_load;
  logic [TW-1:0] tmr_len;
  logic       win_done;

  pwr_pin_filter #(
    .SYNC_STAGES(SYNC_STAGES),
    .FILT_LEN   (FILT_LEN)
  ) u_filt (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (pg_pd_n_i),
    .level_o(pin_lvl)
  );

  pwr_win_timer #(.W(TW)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(tmr_load),
    .len_i (tmr_len),
    .done_o(win_done)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_len  = LOCK_LEN;
    unique case (state_q)
      ST_WAIT_PG: if (pin_lvl) state_d = ST_LATCH;
      ST_LATCH: begin
        state_d  = ST_LOCK;
        tmr_load = 1'b1;
      end
      ST_LOCK: begin
        if (!pin_lvl)      state_d = ST_OFF;
        else if (win_done) state_d = ST_RUN;
      end
      ST_RUN: begin
        if (!pin_lvl) begin
          state_d  = ST_STOP;
          tmr_load = 1'b1;
          tmr_len  = STOP_LEN;
        end
      end
      ST_STOP: if (win_done) state_d = ST_OFF;
      ST_OFF: begin
        if (pin_lvl) begin
          state_d  = ST_LOCK;
          tmr_load = 1'b1;
        end
      end
      default: state_d = ST_WAIT_PG;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_WAIT_PG;
    else        state_q <= state_d;
  end

  assign strap_latch_o = (state_q == ST_LATCH);
  assign osc_en_o      = clocks_live(state_q);
  assign pll_en_o      = clocks_live(state_q);
  assign out_run_o     = (state_q == ST_RUN);

  // R6: outputs only run while oscillator and PLL are enabled
  p_run_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_run_o |-> (pll_en_o && osc_en_o));

  // R5: oscillator is only shut off after the outputs were parked
  p_park_before_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_en_o) |-> !$past(out_run_o));

  // R2: the strap strobe is a single cycle followed by live enables
  p_strap_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strap_latch_o |=> (!strap_latch_o && pll_en_o));

  // R4: outputs are released only when the lock window expires
  p_run_after_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_run_o) |-> ($past(win_done) && $past(pin_lvl)));

endmodule

// File: tb/sim_pwr_seq_top.sv
module sim_pwr_seq_top;
  localparam int SYNC = 2;
  localparam int FILT = 3;
  localparam int LOCK = 20;
  localparam int STOP = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0;
  logic strap, osc_en, pll_en, out_run;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int strap_seen = 0;
  bit run_seen = 0;

  always #2.5 clk = ~clk;

  pwr_seq_top #(
    .SYNC_STAGES(SYNC), .FILT_LEN(FILT), .LOCK_CYC(LOCK), .STOP_CYC(STOP)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .pg_pd_n_i(pin),
    .strap_latch_o(strap), .osc_en_o(osc_en), .pll_en_o(pll_en), .out_run_o(out_run)
  );

  // ---------------- reference model ----------------
  // 0 wait, 1 latch, 2 lock, 3 run, 4 stop, 5 off
  int m_st = 0;
  int m_cnt = 0;
  bit m_lvl = 0;
  bit pin_q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_lvl = 0;
      pin_q.delete();
      for (int i = 0; i < SYNC + FILT; i++) pin_q.push_back(1'b0);
    end else begin
      int hi, lo;
      case (m_st)
        0: if (m_lvl) m_st = 1;
        1: begin m_st = 2; m_cnt = LOCK; end
        2: if (!m_lvl) m_st = 5;
           else begin m_cnt--; if (m_cnt == 0) m_st = 3; end
        3: if (!m_lvl) begin m_st = 4; m_cnt = STOP; end
        4: begin m_cnt--; if (m_cnt == 0) m_st = 5; end
        5: if (m_lvl) begin m_st = 2; m_cnt = LOCK; end
        default: m_st = 0;
      endcase
      hi = 0; lo = 0;
      for (int i = SYNC; i < SYNC + FILT; i++) begin
        if (pin_q[i]) hi++; else lo++;
      end
      if (hi == FILT) m_lvl = 1;
      else if (lo == FILT) m_lvl = 0;
      pin_q.push_front(pin);
      void'(pin_q.pop_back());
    end
    cyc++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      bit e_strap, e_live, e_run;
      e_strap = (m_st == 1);
      e_live  = (m_st >= 1 && m_st <= 4);
      e_run   = (m_st == 3);
      chk(strap == e_strap, "R2 strap_latch_o", strap, e_strap);
      chk(osc_en == e_live, "R5 osc_en_o", osc_en, e_live);
      chk(pll_en == e_live, "R5 pll_en_o", pll_en, e_live);
      chk(out_run == e_run, "R4 out_run_o", out_run, e_run);
      chk(!out_run || (osc_en && pll_en), "R6 run without enables", out_run, 0);
      if (strap) strap_seen++;
      if (out_run) run_seen = 1;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic meas_lock(output int n);
    n = 0;
    while (!pll_en) @(negedge clk);
    while (!out_run) begin n++; @(negedge clk); end
  endtask

  task automatic meas_park(output int n);
    n = 0;
    while (out_run) @(negedge clk);
    while (osc_en) begin n++; @(negedge clk); end
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    while (cyc < 20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  initial begin
    int n;
    idle(4);
    chk(!strap && !osc_en && !pll_en && !out_run, "R1 outputs in reset", out_run, 0);
    rst_n = 1'b1;
    idle(10);
    chk(!pll_en && !out_run, "R1 outputs after reset", pll_en, 0);

    // R3: short high glitch while waiting for power-good
    pin = 1'b1; idle(FILT - 1); pin = 1'b0; idle(20);
    chk(pll_en == 0, "R3 glitch in wait", pll_en, 0);
    chk(strap_seen == 0, "R3 glitch gave strap", strap_seen, 0);

    // R4: first power-good, strobe plus lock window
    pin = 1'b1;
    meas_lock(n);
    chk(n == LOCK + 1, "R4 first lock length", n, LOCK + 1);
    idle(10);

    // R3: short low glitch while running
    pin = 1'b0; idle(FILT - 1); pin = 1'b1; idle(20);
    chk(out_run == 1, "R3 glitch in run", out_run, 1);

    // R5: power-down parks, then shuts off
    pin = 1'b0;
    meas_park(n);
    chk(n == STOP, "R5 park window", n, STOP);
    idle(10);
    chk(!osc_en && !pll_en && !out_run, "R5 off state", osc_en, 0);

    // R3: short high glitch while off
    pin = 1'b1; idle(FILT - 1); pin = 1'b0; idle(20);
    chk(pll_en == 0, "R3 glitch in off", pll_en, 0);

    // R7: wake from off
    pin = 1'b1;
    meas_lock(n);
    chk(n == LOCK, "R7 wake lock length", n, LOCK);
    chk(strap_seen == 1, "R2 single strap after wake", strap_seen, 1);

    // R8: power-down during the lock window
    pin = 1'b0; idle(30);
    run_seen = 0;
    pin = 1'b1;
    while (!pll_en) @(negedge clk);
    idle(5);
    pin = 1'b0; idle(30);
    chk(run_seen == 0, "R8 run during aborted lock", run_seen, 0);
    chk(!pll_en && !osc_en, "R8 off after abort", pll_en, 0);
    chk(strap_seen == 1, "R2 strap count at end", strap_seen, 1);

    finish_run();
  end
endmodule